// File: doc/BRIEF.md
# Descriptor Ring DMA Sequencer

This block walks a circular ring of 16-byte transfer descriptors kept in system memory and carries out the memory-to-memory copies they describe. It fetches each descriptor through a word-wide request/response memory port that uses a valid/ready handshake. When the descriptor is owned by hardware, the block copies the payload from source to destination in bursts that never exceed a programmed maximum. It then writes a completion status and the count of untransferred bytes back into the descriptor's first word, which also clears ownership, and moves on to the next ring slot.

Software fills ring slots and marks them owned. It starts the sequencer and reclaims finished slots by polling the written-back words in memory. A control block supplies the ring base and entry count, the burst-size code and three command strobes: start, graceful pause and abort. The sequencer reports per-descriptor completion, error and invalid-slot conditions, and its busy state.

Top module: `desc_ring_dma`

## Requirements
- R1: Descriptor slot k sits at ring base + 16*k.
  - Word 0 is at offset 0, word 1 at +4, the destination low word at +8 and the source low word at +12.
  - In word 1, bits [15:0] are the destination address bits [47:32] and bits [31:16] are the source address bits [47:32].
- R2: A fetched word 0 whose bit 31 (owned flag) is clear stops the sequencer.
  - No data is moved and nothing is written to that slot.
  - `inv_desc` goes high and `busy` goes low.
- R3: An owned descriptor copies `size` = word0[26:0] bytes from source to destination as 32-bit words, in ascending address order.
  - Size bits [1:0] are ignored.
  - No word past the end of the destination is written.
- R4: The maximum burst is set by `burst_code`: 0 = 64 B, 1 = 128 B, 2 = 256 B, 3 = 512 B, 4 = 1 KB, 5 = 2 KB, 7 = 4 B, and 6 is treated as 64 B.
  - All source reads of a burst are issued before any of its destination writes.
  - The longest run of reads between writes is therefore min(burst, remaining)/4 words.
- R5: A successful copy rewrites word 0 as 0x4000_0000: bit 31 clear, bit 30 success, and a residual size of 0.
- R6: A failed source read stops the copy.
  - Word 0 is rewritten with bit 29 set and bits [26:0] holding the bytes not written.
  - `err_rd` is raised, and the sequencer halts without fetching the next slot.
- R7: A failed destination write stops the copy.
  - Word 0 is rewritten with bit 28 set and the bytes not written.
  - `err_wr` is raised and the sequencer halts.
- R8: `desc_done` pulses for one cycle after a successful write-back, and only if bit 30 of the fetched word 0 was set. Failed descriptors give no pulse.
- R9: After each write-back the slot index advances. It wraps from entry count-1 back to slot 0.
- R10: A graceful pause lets the descriptor in progress finish, including its write-back. The sequencer then stops without fetching the next slot and pulses `pause_done`.
- R11: An abort while busy stops the sequencer on the next cycle.
  - `busy` and `mem_req_valid` go low and `abort_done` pulses.
  - No write-back is made.
  - When abort and pause arrive in the same cycle, only `abort_done` pulses.
- R12: `start` is acted on only while idle. It clears `err_rd`, `err_wr` and `inv_desc` and resumes at the held slot index, which is the same slot after an invalid stop.
- R13: After reset, `busy`, `mem_req_valid`, all error flags and all done pulses are low, and the slot index is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ring_base | input | 48 | Byte address of ring slot 0 |
| ring_count | input | 16 | Number of ring slots |
| burst_code | input | 3 | Maximum burst size code |
| start_req | input | 1 | Begin walking the ring (idle only) |
| pause_req | input | 1 | Graceful pause strobe |
| abort_req | input | 1 | Immediate abort strobe |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 48 | Byte address of the word |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Response for the accepted request |
| mem_rsp_rdata | input | 32 | Read data |
| mem_rsp_err | input | 1 | Request failed |
| busy | output | 1 | Sequencer not idle |
| desc_done | output | 1 | Completion pulse for flagged descriptors |
| pause_done | output | 1 | Graceful pause completed pulse |
| abort_done | output | 1 | Abort completed pulse |
| err_rd | output | 1 | Halted on a read failure |
| err_wr | output | 1 | Halted on a write failure |
| inv_desc | output | 1 | Halted on a slot not owned by hardware |

## Verification
Graceful pause and abort can both be requested in the same clock. The bench raises the two strobes together in the middle of a long 4-byte-burst copy. It judges the outcome by the pulse counters and by the slot's word 0 left in memory: one `abort_done` is expected, `pause_done` must not pulse, and the owned descriptor must remain unwritten. A separate run issues the pause alone, to show that the write-back of the slot in progress does land.

// File: rtl/dseq_pkg.sv
// Shared types and helpers for the descriptor ring sequencer.
// Assumes 32-bit memory words and the 16-byte descriptor layout.
package dseq_pkg;

    typedef enum logic [3:0] {
        S_IDLE, S_FREQ, S_FRSP, S_RREQ, S_RRSP,
        S_WREQ, S_WRSP, S_BREQ, S_BRSP
    } dseq_state_e;

    localparam int OWN_BIT  = 31;
    localparam int INTR_BIT = 30;

    // Status field written back in word 0 bits [30:28]
    localparam logic [2:0] ST_OK   = 3'b100;
    localparam logic [2:0] ST_RDF  = 3'b010;
    localparam logic [2:0] ST_WRF  = 3'b001;

    // Burst code to byte count; code 6 is reserved and behaves as 64 B
    function automatic logic [12:0] burst_bytes(input logic [2:0] code);
        case (code)
            3'd1:    return 13'd128;
            3'd2:    return 13'd256;
            3'd3:    return 13'd512;
            3'd4:    return 13'd1024;
            3'd5:    return 13'd2048;
            3'd7:    return 13'd4;
            default: return 13'd64;
        endcase
    endfunction

endpackage

// File: rtl/dseq_burst_len.sv
// Computes the word count of the next burst: the smaller of the
// programmed maximum and the bytes still to copy. Purely combinational.
// Assumes the remaining byte count is a multiple of four.
module dseq_burst_len
    import dseq_pkg::*;
#(
    parameter int SIZE_W          = 27,
    parameter int MAX_BURST_BYTES = 2048,
    parameter int BW_W            = 10
) (
    input  logic [2:0]        code,
    input  logic [SIZE_W-1:0] rem_bytes,
    output logic [BW_W-1:0]   words
);
    localparam int REM_W = SIZE_W - 2;

    logic [12:0]      max_b;
    logic [REM_W-1:0] rem_w;
    logic [REM_W-1:0] max_w;

    // Clamp the coded size to the buffer and take the minimum
    always_comb begin
        max_b = burst_bytes(code);
        if (max_b > 13'(MAX_BURST_BYTES)) max_b = 13'(MAX_BURST_BYTES);
        max_w = REM_W'(max_b[12:2]);
        rem_w = rem_bytes[SIZE_W-1:2];
        words = (rem_w < max_w) ? BW_W'(rem_w) : BW_W'(max_w);
    end

endmodule

// File: rtl/dseq_ring_ptr.sv
// Holds the current ring slot index and forms the slot's byte address.
// Advances on request and wraps to slot 0 after the last entry.
// Assumes ring_count is non-zero and stable while the sequencer runs.
module dseq_ring_ptr #(
    parameter int ADDR_W = 48,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] ring_base,
    input  logic [CNT_W-1:0]  ring_count,
    input  logic              advance,
    output logic [ADDR_W-1:0] slot_addr
);
    logic [CNT_W-1:0] idx_q;
    logic             at_last;

    assign at_last   = (CNT_W+1)'(idx_q) + 1'b1 >= (CNT_W+1)'(ring_count);
    assign slot_addr = ring_base + ADDR_W'({idx_q, 4'b0000});

    // Slot index register with wrap
    always_ff @(posedge clk) begin
        if (!rst_n)       idx_q <= '0;
        else if (advance) idx_q <= at_last ? '0 : idx_q + 1'b1;
    end

    p_idx_in_ring_r9: assert property (@(posedge clk) disable iff (!rst_n)
        advance |=> (idx_q < ring_count));

endmodule

// File: rtl/dseq_buf.sv
// Burst staging buffer: one write port, one asynchronous read port.
// Contents are not reset; every word is written before it is read.
module dseq_buf #(
    parameter int DEPTH  = 512,
    parameter int DATA_W = 32,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem [DEPTH];

    // Store read data of the current burst
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/desc_ring_dma.sv
// Descriptor ring sequencer: fetches 16-byte descriptors, copies the
// payload in bounded bursts, writes status and residual back to word 0.
// Assumes one outstanding memory request and in-order responses.
module desc_ring_dma
    import dseq_pkg::*;
#(
    parameter int HI_W            = 16,
    parameter int LO_W            = 32,
    parameter int DATA_W          = 32,
    parameter int SIZE_W          = 27,
    parameter int CNT_W           = 16,
    parameter int MAX_BURST_BYTES = 2048,
    localparam int ADDR_W         = HI_W + LO_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] ring_base,
    input  logic [CNT_W-1:0]  ring_count,
    input  logic [2:0]        burst_code,
    input  logic              start_req,
    input  logic              pause_req,
    input  logic              abort_req,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_we,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [DATA_W-1:0] mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_rdata,
    input  logic              mem_rsp_err,
    output logic              busy,
    output logic              desc_done,
    output logic              pause_done,
    output logic              abort_done,
    output logic              err_rd,
    output logic              err_wr,
    output logic              inv_desc
);
    localparam int BUF_WORDS = MAX_BURST_BYTES / 4;
    localparam int BUF_AW    = $clog2(BUF_WORDS);
    localparam int BW_W      = BUF_AW + 1;

    dseq_state_e       state_q;
    logic [1:0]        fw_q;
    logic [ADDR_W-1:0] src_q, dst_q, slot_addr;
    logic [SIZE_W-1:0] rem_q, off_q, resid_q;
    logic [BW_W-1:0]   bi_q, bw;
    logic [2:0]        st_q;
    logic              intr_q, pause_pend_q;
    logic              done_q, pdone_q, adone_q, erd_q, ewr_q, inv_q;
    logic              advance, buf_we, last_in_burst;
    logic [DATA_W-1:0] buf_rd;
    logic [SIZE_W-1:0] cur_off, burst_bytes_w;

    assign busy          = (state_q != S_IDLE);
    assign cur_off       = off_q + SIZE_W'({bi_q, 2'b00});
    assign burst_bytes_w = SIZE_W'({bw, 2'b00});
    assign last_in_burst = (BW_W'(bi_q + 1'b1) == bw);
    assign advance       = (state_q == S_BRSP) && mem_rsp_valid && !abort_req;
    assign buf_we        = (state_q == S_RRSP) && mem_rsp_valid && !mem_rsp_err;

    dseq_ring_ptr #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ptr (
        .clk(clk), .rst_n(rst_n), .ring_base(ring_base),
        .ring_count(ring_count), .advance(advance), .slot_addr(slot_addr)
    );

    dseq_burst_len #(.SIZE_W(SIZE_W), .MAX_BURST_BYTES(MAX_BURST_BYTES),
                     .BW_W(BW_W)) u_blen (
        .code(burst_code), .rem_bytes(rem_q), .words(bw)
    );

    dseq_buf #(.DEPTH(BUF_WORDS), .DATA_W(DATA_W)) u_buf (
        .clk(clk), .wr_en(buf_we), .wr_addr(bi_q[BUF_AW-1:0]),
        .wr_data(mem_rsp_rdata), .rd_addr(bi_q[BUF_AW-1:0]), .rd_data(buf_rd)
    );

    // Memory request fields from the current state
    always_comb begin
        mem_req_valid = 1'b0;
        mem_req_we    = 1'b0;
        mem_req_addr  = '0;
        mem_req_wdata = '0;
        case (state_q)
            S_FREQ: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = slot_addr + ADDR_W'({fw_q, 2'b00});
            end
            S_RREQ: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = src_q + ADDR_W'(cur_off);
            end
            S_WREQ: begin
                mem_req_valid = 1'b1;
                mem_req_we    = 1'b1;
                mem_req_addr  = dst_q + ADDR_W'(cur_off);
                mem_req_wdata = buf_rd;
            end
            S_BREQ: begin
                mem_req_valid = 1'b1;
                mem_req_we    = 1'b1;
                mem_req_addr  = slot_addr;
                mem_req_wdata = {1'b0, st_q, 1'b0, resid_q};
            end
            default: ;
        endcase
    end

    // Sequencer state, descriptor fields and status flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= S_IDLE;
            fw_q         <= '0;
            src_q        <= '0;
            dst_q        <= '0;
            rem_q        <= '0;
            off_q        <= '0;
            resid_q      <= '0;
            bi_q         <= '0;
            st_q         <= '0;
            intr_q       <= 1'b0;
            pause_pend_q <= 1'b0;
            done_q       <= 1'b0;
            pdone_q      <= 1'b0;
            adone_q      <= 1'b0;
            erd_q        <= 1'b0;
            ewr_q        <= 1'b0;
            inv_q        <= 1'b0;
        end else begin
            done_q  <= 1'b0;
            pdone_q <= 1'b0;
            adone_q <= 1'b0;
            if (busy && pause_req) pause_pend_q <= 1'b1;
            if (busy && abort_req) begin
                state_q      <= S_IDLE;
                adone_q      <= 1'b1;
                pause_pend_q <= 1'b0;
            end else begin
                case (state_q)
                    S_IDLE: if (start_req) begin
                        state_q      <= S_FREQ;
                        fw_q         <= '0;
                        erd_q        <= 1'b0;
                        ewr_q        <= 1'b0;
                        inv_q        <= 1'b0;
                        pause_pend_q <= 1'b0;
                    end
                    S_FREQ: if (mem_req_ready) state_q <= S_FRSP;
                    S_FRSP: if (mem_rsp_valid) begin
                        if (mem_rsp_err) begin
                            erd_q        <= 1'b1;
                            state_q      <= S_IDLE;
                            pause_pend_q <= 1'b0;
                        end else begin
                            case (fw_q)
                                2'd0: begin
                                    if (!mem_rsp_rdata[OWN_BIT]) begin
                                        inv_q        <= 1'b1;
                                        state_q      <= S_IDLE;
                                        pause_pend_q <= 1'b0;
                                    end else begin
                                        intr_q  <= mem_rsp_rdata[INTR_BIT];
                                        rem_q   <= {mem_rsp_rdata[SIZE_W-1:2], 2'b00};
                                        fw_q    <= 2'd1;
                                        state_q <= S_FREQ;
                                    end
                                end
                                2'd1: begin
                                    dst_q[ADDR_W-1:LO_W] <= mem_rsp_rdata[HI_W-1:0];
                                    src_q[ADDR_W-1:LO_W] <= mem_rsp_rdata[DATA_W-1:HI_W];
                                    fw_q    <= 2'd2;
                                    state_q <= S_FREQ;
                                end
                                2'd2: begin
                                    dst_q[LO_W-1:0] <= mem_rsp_rdata;
                                    fw_q    <= 2'd3;
                                    state_q <= S_FREQ;
                                end
                                default: begin
                                    src_q[LO_W-1:0] <= mem_rsp_rdata;
                                    off_q <= '0;
                                    bi_q  <= '0;
                                    if (rem_q == '0) begin
                                        st_q    <= ST_OK;
                                        resid_q <= '0;
                                        state_q <= S_BREQ;
                                    end else begin
                                        state_q <= S_RREQ;
                                    end
                                end
                            endcase
                        end
                    end
                    S_RREQ: if (mem_req_ready) state_q <= S_RRSP;
                    S_RRSP: if (mem_rsp_valid) begin
                        if (mem_rsp_err) begin
                            st_q    <= ST_RDF;
                            resid_q <= rem_q;
                            state_q <= S_BREQ;
                        end else if (last_in_burst) begin
                            bi_q    <= '0;
                            state_q <= S_WREQ;
                        end else begin
                            bi_q    <= bi_q + 1'b1;
                            state_q <= S_RREQ;
                        end
                    end
                    S_WREQ: if (mem_req_ready) state_q <= S_WRSP;
                    S_WRSP: if (mem_rsp_valid) begin
                        if (mem_rsp_err) begin
                            st_q    <= ST_WRF;
                            resid_q <= rem_q - SIZE_W'({bi_q, 2'b00});
                            state_q <= S_BREQ;
                        end else if (last_in_burst) begin
                            bi_q  <= '0;
                            off_q <= off_q + burst_bytes_w;
                            rem_q <= rem_q - burst_bytes_w;
                            if (rem_q == burst_bytes_w) begin
                                st_q    <= ST_OK;
                                resid_q <= '0;
                                state_q <= S_BREQ;
                            end else begin
                                state_q <= S_RREQ;
                            end
                        end else begin
                            bi_q    <= bi_q + 1'b1;
                            state_q <= S_WREQ;
                        end
                    end
                    S_BREQ: if (mem_req_ready) state_q <= S_BRSP;
                    S_BRSP: if (mem_rsp_valid) begin
                        if (mem_rsp_err || st_q != ST_OK) begin
                            erd_q        <= (st_q == ST_RDF);
                            ewr_q        <= mem_rsp_err || (st_q == ST_WRF);
                            state_q      <= S_IDLE;
                            pause_pend_q <= 1'b0;
                        end else begin
                            done_q <= intr_q;
                            if (pause_pend_q || pause_req) begin
                                pdone_q      <= 1'b1;
                                state_q      <= S_IDLE;
                                pause_pend_q <= 1'b0;
                            end else begin
                                fw_q    <= '0;
                                state_q <= S_FREQ;
                            end
                        end
                    end
                    default: state_q <= S_IDLE;
                endcase
            end
        end
    end

    assign desc_done  = done_q;
    assign pause_done = pdone_q;
    assign abort_done = adone_q;
    assign err_rd     = erd_q;
    assign err_wr     = ewr_q;
    assign inv_desc   = inv_q;

    p_req_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready && !abort_req
        |=> mem_req_valid && $stable(mem_req_addr));

    p_inv_halts_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(inv_desc) |-> !busy);

    p_burst_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RREQ || state_q == S_WREQ) |-> (bi_q < bw));

    p_err_halts_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(err_rd) || $rose(err_wr)) |-> !busy);

    p_abort_stops_r11: assert property (@(posedge clk) disable iff (!rst_n)
        busy && abort_req |=> !busy && abort_done && !mem_req_valid);

    p_abort_excl_pause_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(abort_done && pause_done));

endmodule

// File: tb/tb_desc_ring_dma.sv
`timescale 1ns/1ps
module tb_desc_ring_dma;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [47:0] ring_base = 48'h0;
    logic [15:0] ring_count = 16'd4;
    logic [2:0]  burst_code = 3'd0;
    logic        start_req = 1'b0, pause_req = 1'b0, abort_req = 1'b0;
    logic        mem_req_valid, mem_req_we;
    logic        mem_req_ready;
    logic [47:0] mem_req_addr;
    logic [31:0] mem_req_wdata;
    logic        mem_rsp_valid, mem_rsp_err;
    logic [31:0] mem_rsp_rdata;
    logic        busy, desc_done, pause_done, abort_done, err_rd, err_wr, inv_desc;

    always #2 clk = ~clk;

    desc_ring_dma dut (
        .clk(clk), .rst_n(rst_n), .ring_base(ring_base), .ring_count(ring_count),
        .burst_code(burst_code), .start_req(start_req), .pause_req(pause_req),
        .abort_req(abort_req), .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we),
        .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
        .mem_rsp_err(mem_rsp_err), .busy(busy), .desc_done(desc_done),
        .pause_done(pause_done), .abort_done(abort_done), .err_rd(err_rd),
        .err_wr(err_wr), .inv_desc(inv_desc)
    );

    // size[39:24] code[23:20] intr[16] expected longest read run [15:0]
    localparam logic [39:0] VEC [5] = '{
        {16'd64,  4'd0, 4'd1, 16'd16},
        {16'd200, 4'd7, 4'd0, 16'd1},
        {16'd300, 4'd1, 4'd1, 16'd32},
        {16'd520, 4'd2, 4'd1, 16'd64},
        {16'd12,  4'd6, 4'd0, 16'd3}
    };

    logic [31:0] mem [0:1023];
    int n_chk = 0, n_fail = 0;
    int n_done = 0, n_pause = 0, n_abort = 0;
    int run_cur = 0, run_max = 0, rdy_cnt = 0;
    logic [15:0] hi;
    logic [9:0]  widx;
    logic        bad;

    // Memory model with one-cycle response and a stalling ready pattern
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_req_ready <= 1'b0;
            mem_rsp_valid <= 1'b0;
            mem_rsp_err   <= 1'b0;
            mem_rsp_rdata <= '0;
        end else begin
            rdy_cnt = rdy_cnt + 1;
            mem_req_ready <= (rdy_cnt % 5) != 3;
            mem_rsp_valid <= mem_req_valid && mem_req_ready;
            if (mem_req_valid && mem_req_ready) begin
                hi   = mem_req_addr[47:32];
                widx = mem_req_addr[11:2];
                bad  = (!mem_req_we && hi == 16'h00EE) || (mem_req_we && hi == 16'h00FF);
                mem_rsp_err   <= bad;
                mem_rsp_rdata <= mem[widx];
                if (mem_req_we && !bad) mem[widx] = mem_req_wdata;
                if (mem_req_we) run_cur = 0;
                else if (mem_req_addr[11:0] >= 12'h100 && mem_req_addr[11:0] < 12'h800) begin
                    run_cur = run_cur + 1;
                    if (run_cur > run_max) run_max = run_cur;
                end
            end
            if (desc_done)  n_done  = n_done + 1;
            if (pause_done) n_pause = n_pause + 1;
            if (abort_done) n_abort = n_abort + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic go();
        @(negedge clk) start_req = 1'b1;
        @(negedge clk) start_req = 1'b0;
    endtask

    task automatic wait_idle(input string tag);
        for (int k = 0; k < 20000 && busy; k++) @(negedge clk);
        if (busy) chk(1'b0, tag, 1, 0);
        clks(2);
    endtask

    task automatic put_desc(input int slot, input logic [31:0] w0, input logic [31:0] w1,
                            input logic [31:0] w2, input logic [31:0] w3);
        mem[slot*4]   = w0;
        mem[slot*4+1] = w1;
        mem[slot*4+2] = w2;
        mem[slot*4+3] = w3;
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        finish_up();
    end

    initial begin
        int p0, a0, d0;
        logic [31:0] keep;
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        clks(4);
        rst_n = 1'b1;
        clks(1);
        // R13: reset state
        chk(!busy && !mem_req_valid, "R13 idle after reset", {busy, mem_req_valid}, 0);
        chk(!err_rd && !err_wr && !inv_desc, "R13 flags clear", {err_rd, err_wr, inv_desc}, 0);
        chk(!desc_done && !pause_done && !abort_done, "R13 pulses low",
            {desc_done, pause_done, abort_done}, 0);

        // Vector table: each run resumes at the held slot (R12) and stops on the next empty one
        for (int v = 0; v < 5; v++) begin
            logic [39:0] e;
            int sz, slot, nxt, mism;
            e    = VEC[v];
            sz   = int'(e[39:24]);
            slot = v % 4;
            nxt  = (v + 1) % 4;
            put_desc(slot, {1'b1, e[16], 3'b000, 27'(sz)}, 32'h0, 32'h800, 32'h100);
            mem[nxt*4] = '0;
            for (int i = 0; i < sz/4; i++) begin
                mem[64+i]  = 32'hA500_0000 | (v << 16) | i;
                mem[512+i] = 32'hDEAD_BEEF;
            end
            mem[512 + sz/4] = 32'hDEAD_BEEF;
            burst_code = e[22:20];
            run_max = 0;
            run_cur = 0;
            d0 = n_done;
            go();
            wait_idle("vector run timeout");
            mism = 0;
            for (int i = 0; i < sz/4; i++)
                if (mem[512+i] != (32'hA500_0000 | (v << 16) | i)) mism++;
            chk(mism == 0, "R3 copied data", mism, 0);
            chk(mem[512 + sz/4] == 32'hDEAD_BEEF, "R3 no overrun", mem[512 + sz/4], 32'hDEAD_BEEF);
            chk(mem[slot*4] == 32'h4000_0000, (v == 4) ? "R9 wrap write-back slot 0" : "R5 write-back",
                mem[slot*4], 32'h4000_0000);
            chk(run_max == int'(e[15:0]), "R4 burst read run", run_max, e[15:0]);
            chk(n_done - d0 == int'(e[16]), "R8 done pulse", n_done - d0, e[16]);
            chk(inv_desc && !busy, "R2 invalid stop", inv_desc, 1);
            chk(mem[nxt*4] == 32'h0, "R2 invalid slot untouched", mem[nxt*4], 0);
        end

        // R6/R1: read failure via source high address part, slot 1
        put_desc(1, {1'b1, 1'b1, 3'b000, 27'd64}, {16'h00EE, 16'h0000}, 32'h800, 32'h100);
        mem[8] = '0;
        burst_code = 3'd0;
        d0 = n_done;
        go();
        wait_idle("read fail timeout");
        chk(mem[4] == 32'h2000_0040, "R6 R1 read-fail write-back", mem[4], 32'h2000_0040);
        chk(err_rd && !err_wr, "R6 err_rd raised", {err_rd, err_wr}, 2'b10);
        chk(!inv_desc && !busy, "R6 halted before next fetch", inv_desc, 0);
        chk(n_done == d0, "R8 no pulse on failure", n_done - d0, 0);

        // R7/R1: write failure via destination high address part, slot 2
        put_desc(2, {1'b1, 1'b0, 3'b000, 27'd32}, {16'h0000, 16'h00FF}, 32'h800, 32'h100);
        mem[12] = '0;
        go();
        wait_idle("write fail timeout");
        chk(mem[8] == 32'h1000_0020, "R7 R1 write-fail write-back", mem[8], 32'h1000_0020);
        chk(err_wr, "R7 err_wr raised", err_wr, 1);
        chk(!err_rd, "R12 start clears err_rd", err_rd, 0);

        // R10: graceful pause during slot 3, slot 0 owned but must not be taken
        keep = {1'b1, 1'b0, 3'b000, 27'd16};
        put_desc(3, {1'b1, 1'b0, 3'b000, 27'd256}, 32'h0, 32'h800, 32'h100);
        put_desc(0, keep, 32'h0, 32'h800, 32'h100);
        mem[4] = '0;
        burst_code = 3'd7;
        p0 = n_pause;
        go();
        clks(20);
        pause_req = 1'b1;
        clks(1);
        pause_req = 1'b0;
        wait_idle("pause timeout");
        chk(mem[12] == 32'h4000_0000, "R10 current slot completes", mem[12], 32'h4000_0000);
        chk(mem[0] == keep, "R10 next slot not taken", mem[0], keep);
        chk(n_pause == p0 + 1, "R10 pause_done pulse", n_pause - p0, 1);
        chk(!inv_desc && !busy, "R10 clean stop", inv_desc, 0);

        // R11: abort mid-transfer on slot 0
        keep = {1'b1, 1'b1, 3'b000, 27'd256};
        mem[0] = keep;
        a0 = n_abort;
        go();
        clks(20);
        @(negedge clk) abort_req = 1'b1;
        @(negedge clk) abort_req = 1'b0;
        chk(!busy && !mem_req_valid, "R11 stops next cycle", {busy, mem_req_valid}, 0);
        clks(2);
        chk(n_abort == a0 + 1, "R11 abort_done pulse", n_abort - a0, 1);
        chk(mem[0] == keep, "R11 no write-back", mem[0], keep);

        // R11: abort and pause in the same cycle, abort wins
        p0 = n_pause;
        go();
        clks(20);
        @(negedge clk) begin abort_req = 1'b1; pause_req = 1'b1; end
        @(negedge clk) begin abort_req = 1'b0; pause_req = 1'b0; end
        clks(4);
        chk(n_abort == a0 + 2, "R11 same-cycle abort pulse", n_abort - a0, 2);
        chk(n_pause == p0, "R11 same-cycle no pause_done", n_pause - p0, 0);
        chk(mem[0] == keep && !busy, "R11 same-cycle slot kept", mem[0], keep);

        finish_up();
    end

endmodule